// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives stereo audio from an external master over three lines: a bit clock, a word-select line and a serial data line. The block is a slave only, so all three lines are inputs. It samples them with its own system clock, which runs many times faster than the bit clock and is frequency-locked to it. From these lines it rebuilds one left and one right sample per sample period. Each sample is presented as a 20-bit two's-complement value together with a one-cycle strobe for its channel.

Three framing families are decoded. In I2S, the most significant bit follows the word-select edge by one bit clock. In MSB-justified framing, the most significant bit arrives with the edge. In LSB-justified framing, the sample is right-aligned against the next edge and is 16, 18 or 20 bits wide. The wanted format comes either from a 3-bit register field or, when static-pin mode is selected, from a 2-bit pin select. The pin select can reach only I2S and the three LSB-justified widths. A new format is adopted only at the start of a frame, so a frame is never decoded half in one format and half in another.

Top module: `serial_audio_rx`

## Requirements
- R1: With format code 000 (I2S), the first data bit after a word-select change is the sample MSB. Up to 20 following bits are placed MSB-first into the output, starting at bit 19. Unsent low bits read as zero, and bits past the twentieth are ignored. The word's last slot bit, sampled together with the next word-select change, still belongs to that word.
- R2: Any register format code with bit 2 set (1xx) selects MSB-justified framing. The bit sampled together with the word-select change is the MSB, and the later bits are placed as in R1.
- R3: Codes 001, 010 and 011 select LSB-justified framing of 16, 18 and 20 bits. The bit just before the next word-select change is the LSB. Earlier padding bits are ignored, and 16- and 18-bit samples are sign-extended to 20 bits.
- R4: When use_pins is 1, the format is {0, pin_fmt}: 00 I2S, 01 LSB-16, 10 LSB-18, 11 LSB-20. reg_fmt has no effect in that mode, so MSB-justified framing cannot be reached.
- R5: Word select low carries the left sample and high carries the right. A completed left word appears on left_sample with left_strobe, and a completed right word appears on right_sample with right_strobe.
- R6: Each strobe is high for exactly one system-clock cycle per completed word. The two strobes are never high together.
- R7: A format change on the configuration inputs takes effect only at a falling word-select edge, which is the start of a frame. The right word of the frame in progress is still decoded in the old format.
- R8: After reset, both samples read 0 and no strobe fires until a falling word-select edge has been seen. Line data is sampled on rising bit-clock edges after synchronisation to the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency-locked to the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock from the master |
| word_sel | input | 1 | Word select: 0 left, 1 right |
| ser_data | input | 1 | Serial audio data |
| use_pins | input | 1 | 1 selects static-pin format control |
| pin_fmt | input | 2 | Static format select |
| reg_fmt | input | 3 | Register format code |
| left_sample | output | 20 | Last left sample, sign-extended |
| left_strobe | output | 1 | One-cycle pulse when left_sample updates |
| right_sample | output | 20 | Last right sample, sign-extended |
| right_strobe | output | 1 | One-cycle pulse when right_sample updates |

## Verification
A wrong bit counter or a wrong alignment register shows up at the first strobe after the fault. The sample is then shifted, truncated or wrongly extended, and the per-strobe comparison against the bench model catches it within one half-frame. A wrong latched format, or a format taken at the wrong edge, corrupts the right word of the switching frame and the words after it. A wrong channel flag gives a strobe on the wrong side at the very next word-select edge.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
    localparam logic [2:0] FMT_I2S   = 3'b000;
    localparam logic [2:0] FMT_LSB16 = 3'b001;
    localparam logic [2:0] FMT_LSB18 = 3'b010;
    localparam logic [2:0] FMT_LSB20 = 3'b011;
    localparam logic [2:0] FMT_MSBJ  = 3'b100;

    function automatic logic fmt_is_i2s(input logic [2:0] f);
        return f == FMT_I2S;
    endfunction

    function automatic logic fmt_is_msbj(input logic [2:0] f);
        return f[2];
    endfunction
endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic rise_o,
    output logic ws_o,
    output logic sd_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][2:0] pipe;
        logic                   sck_last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d         = sync_q;
        sync_d.pipe[0] = {sck_i, ws_i, sd_i};
        for (int i = 1; i < STAGES; i++) begin
            sync_d.pipe[i] = sync_q.pipe[i-1];
        end
        sync_d.sck_last = sync_q.pipe[LAST][2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rise_o = sync_q.pipe[LAST][2] & ~sync_q.sck_last;
    assign ws_o   = sync_q.pipe[LAST][1];
    assign sd_o   = sync_q.pipe[LAST][0];
endmodule

// File: rtl/sarx_cfg_mux.sv
module sarx_cfg_mux (
    input  logic       use_pins_i,
    input  logic [1:0] pin_fmt_i,
    input  logic [2:0] reg_fmt_i,
    output logic [2:0] fmt_o
);
    always_comb begin
        if (use_pins_i) begin
            fmt_o = {1'b0, pin_fmt_i};
        end else begin
            fmt_o = reg_fmt_i;
        end
    end
endmodule

// File: rtl/sarx_assemble.sv
module sarx_assemble
    import sarx_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_i,
    input  logic         ws_i,
    input  logic         sd_i,
    input  logic [2:0]   fmt_req_i,
    output logic [W-1:0] l_data_o,
    output logic         l_vld_o,
    output logic [W-1:0] r_data_o,
    output logic         r_vld_o,
    output logic [2:0]   mode_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          ws_prev;
        logic          primed;
        logic [2:0]    mode;
        logic [CW-1:0] cnt;
        logic [W-1:0]  acc;
        logic [W-1:0]  sr;
        logic [W-1:0]  l_data;
        logic [W-1:0]  r_data;
        logic          l_vld;
        logic          r_vld;
    } asm_t;

    asm_t asm_d, asm_q;

    // place bit b at position W-1-c when c is still inside the word
    function automatic logic [W-1:0] put_bit(input logic [W-1:0] a,
                                             input logic [CW-1:0] c,
                                             input logic b);
        logic [W-1:0] r;
        r = a;
        for (int i = 0; i < W; i++) begin
            if (i == W - 1 - int'(c)) r[i] = b;
        end
        return r;
    endfunction

    // right-aligned sample of width W-4, W-2 or W, sign-extended to W
    function automatic logic [W-1:0] sext(input logic [W-1:0] v,
                                          input logic [1:0] sel);
        logic [W-1:0] r;
        logic         sb;
        int           n;
        n  = (sel == 2'd1) ? W - 4 : (sel == 2'd2) ? W - 2 : W;
        sb = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i == n - 1) sb = v[i];
        end
        r = v;
        for (int i = 0; i < W; i++) begin
            if (i >= n) r[i] = sb;
        end
        return r;
    endfunction

    logic [W-1:0] fin;
    logic [2:0]   nmode;
    logic         ws_edge;

    always_comb begin
        asm_d       = asm_q;
        asm_d.l_vld = 1'b0;
        asm_d.r_vld = 1'b0;
        fin         = '0;
        nmode       = asm_q.mode;
        ws_edge     = 1'b0;
        if (rise_i) begin
            ws_edge = ws_i != asm_q.ws_prev;
            if (fmt_is_i2s(asm_q.mode)) begin
                fin = put_bit(asm_q.acc, asm_q.cnt, sd_i);
            end else if (fmt_is_msbj(asm_q.mode)) begin
                fin = asm_q.acc;
            end else begin
                fin = sext(asm_q.sr, asm_q.mode[1:0]);
            end
            asm_d.sr      = {asm_q.sr[W-2:0], sd_i};
            asm_d.ws_prev = ws_i;
            if (ws_edge) begin
                if (asm_q.primed) begin
                    if (asm_q.ws_prev) begin
                        asm_d.r_data = fin;
                        asm_d.r_vld  = 1'b1;
                    end else begin
                        asm_d.l_data = fin;
                        asm_d.l_vld  = 1'b1;
                    end
                end
                if (!ws_i) begin
                    nmode        = fmt_req_i;
                    asm_d.mode   = nmode;
                    asm_d.primed = 1'b1;
                end
                asm_d.acc = '0;
                asm_d.cnt = '0;
                if (fmt_is_msbj(nmode)) begin
                    asm_d.acc = put_bit('0, '0, sd_i);
                    asm_d.cnt = CW'(1);
                end
            end else if (int'(asm_q.cnt) < W) begin
                asm_d.acc = put_bit(asm_q.acc, asm_q.cnt, sd_i);
                asm_d.cnt = asm_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else begin
            asm_q <= asm_d;
        end
    end

    assign l_data_o = asm_q.l_data;
    assign l_vld_o  = asm_q.l_vld;
    assign r_data_o = asm_q.r_data;
    assign r_vld_o  = asm_q.r_vld;
    assign mode_o   = asm_q.mode;
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
    parameter int SAMPLE_W    = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_clk,
    input  logic                word_sel,
    input  logic                ser_data,
    input  logic                use_pins,
    input  logic [1:0]          pin_fmt,
    input  logic [2:0]          reg_fmt,
    output logic [SAMPLE_W-1:0] left_sample,
    output logic                left_strobe,
    output logic [SAMPLE_W-1:0] right_sample,
    output logic                right_strobe
);
    logic       rise_w;
    logic       ws_w;
    logic       sd_w;
    logic [2:0] req_w;
    logic [2:0] mode_w;

    sarx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (bit_clk),
        .ws_i   (word_sel),
        .sd_i   (ser_data),
        .rise_o (rise_w),
        .ws_o   (ws_w),
        .sd_o   (sd_w)
    );

    sarx_cfg_mux i_cfg (
        .use_pins_i (use_pins),
        .pin_fmt_i  (pin_fmt),
        .reg_fmt_i  (reg_fmt),
        .fmt_o      (req_w)
    );

    sarx_assemble #(.W(SAMPLE_W)) i_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise_w),
        .ws_i      (ws_w),
        .sd_i      (sd_w),
        .fmt_req_i (req_w),
        .l_data_o  (left_sample),
        .l_vld_o   (left_strobe),
        .r_data_o  (right_sample),
        .r_vld_o   (right_strobe),
        .mode_o    (mode_w)
    );
endmodule

// File: rtl/sarx_chk.sv
module sarx_chk #(
    parameter int W = 20
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rise,
    input logic         ws_bit,
    input logic [2:0]   mode,
    input logic         left_strobe,
    input logic         right_strobe,
    input logic [W-1:0] left_sample
);
    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_strobe && right_strobe));

    // R6
    left_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_strobe |=> !left_strobe);

    // R6
    right_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        right_strobe |=> !right_strobe);

    // R5
    left_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_strobe |-> $past(rise && ws_bit));

    // R5
    right_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        right_strobe |-> $past(rise && !ws_bit));

    // R7
    mode_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> $past(rise && !ws_bit));

    // R3
    lsb16_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_strobe && mode == 3'b001) |->
            ($countones(left_sample[W-1:W-5]) == 0 || $countones(left_sample[W-1:W-5]) == 5));
endmodule

bind serial_audio_rx sarx_chk #(.W(SAMPLE_W)) i_sarx_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise         (rise_w),
    .ws_bit       (ws_w),
    .mode         (mode_w),
    .left_strobe  (left_strobe),
    .right_strobe (right_strobe),
    .left_sample  (left_sample)
);

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 24;
    localparam int HALF_BCK   = 4;

    typedef struct {
        bit          ch;
        logic [19:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_clk = 1'b0;
    logic        word_sel = 1'b1;
    logic        ser_data = 1'b0;
    logic        use_pins = 1'b1;
    logic [1:0]  pin_fmt = 2'b00;
    logic [2:0]  reg_fmt = 3'b000;
    logic [19:0] left_sample;
    logic        left_strobe;
    logic [19:0] right_sample;
    logic        right_strobe;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   started = 0;
    bit   carry = 0;
    logic prev_l = 0;
    logic prev_r = 0;
    exp_t expq[$];

    logic       nxt_pins;
    logic [1:0] nxt_sel;
    logic [2:0] nxt_reg;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_audio_rx i_serial_audio_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_clk      (bit_clk),
        .word_sel     (word_sel),
        .ser_data     (ser_data),
        .use_pins     (use_pins),
        .pin_fmt      (pin_fmt),
        .reg_fmt      (reg_fmt),
        .left_sample  (left_sample),
        .left_strobe  (left_strobe),
        .right_sample (right_sample),
        .right_strobe (right_strobe)
    );

    function automatic logic [2:0] eff_fmt(input logic p, input logic [1:0] s, input logic [2:0] r);
        return p ? {1'b0, s} : r;
    endfunction

    function automatic int lsb_w(input logic [2:0] f);
        return (f == 3'b001) ? 16 : (f == 3'b010) ? 18 : 20;
    endfunction

    // expected 20-bit output for a word s of n significant bits in format f
    function automatic logic [19:0] expect_val(input logic [2:0] f, input int n, input logic [19:0] s);
        logic [19:0] r;
        int          w;
        if (f == 3'b000 || f[2]) begin
            r = s << (20 - n);
        end else begin
            w = lsb_w(f);
            r = s;
            for (int i = w; i < 20; i++) r[i] = s[w-1];
        end
        return r;
    endfunction

    function automatic logic lay(input logic [2:0] f, input int n, input logic [19:0] s, input int p);
        int w;
        if (f == 3'b000 || f[2]) begin
            if (p < n) return s[n-1-p];
            if (p < 20) return 1'b0;
            return 1'($urandom);
        end
        w = lsb_w(f);
        if (p >= SLOT - w) return s[SLOT-1-p];
        return 1'($urandom);
    endfunction

    task automatic send_bit(input logic w, input logic d);
        @(negedge clk);
        word_sel = w;
        ser_data = d;
        repeat (HALF_BCK) @(negedge clk);
        bit_clk = 1'b1;
        repeat (HALF_BCK) @(negedge clk);
        bit_clk = 1'b0;
    endtask

    task automatic send_slot(input logic w, input logic [2:0] f, input int n,
                             input logic [19:0] s, input bit apply);
        logic l [SLOT];
        logic d;
        for (int p = 0; p < SLOT; p++) l[p] = lay(f, n, s, p);
        for (int p = 0; p < SLOT; p++) begin
            if (f == 3'b000) d = (p == 0) ? carry : l[p-1];
            else             d = l[p];
            // R7: configuration moves mid-slot, away from any frame start
            if (apply && p == 3) begin
                use_pins = nxt_pins;
                pin_fmt  = nxt_sel;
                reg_fmt  = nxt_reg;
            end
            send_bit(w, d);
        end
        carry = l[SLOT-1];
    endtask

    // one frame in format f; applies the pending configuration mid-left slot
    task automatic frame(input logic [2:0] f, input int n, input bit apply, input string tag);
        logic [19:0] ls, rs;
        int          bits;
        exp_t        e;
        bits = (f == 3'b000 || f[2]) ? n : lsb_w(f);
        ls = 20'($urandom) & ((20'h1 << bits) - 20'h1);
        rs = 20'($urandom) & ((20'h1 << bits) - 20'h1);
        if (bits == 20) begin
            ls = 20'($urandom);
            rs = 20'($urandom);
        end
        e.ch = 0; e.val = expect_val(f, n, ls); e.tag = tag;
        expq.push_back(e);
        e.ch = 1; e.val = expect_val(f, n, rs); e.tag = apply ? "R7" : tag;
        expq.push_back(e);
        send_slot(1'b0, f, n, ls, apply);
        send_slot(1'b1, f, n, rs, 1'b0);
    endtask

    task automatic run(input logic p, input logic [1:0] s, input logic [2:0] r,
                       input int n, input int cnt, input string tag);
        logic [2:0] f;
        f = eff_fmt(use_pins, pin_fmt, reg_fmt);
        nxt_pins = p; nxt_sel = s; nxt_reg = r;
        frame(f, n, 1'b1, tag);
        f = eff_fmt(p, s, r);
        for (int k = 0; k < cnt; k++) frame(f, n, 1'b0, tag);
    endtask

    // reference comparison on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (left_strobe && right_strobe) begin
                n_chk++; n_bad++;
                $display("FAIL R6 both strobes high: actual 2 strobes, expected 1");
            end
            if ((left_strobe && prev_l) || (right_strobe && prev_r)) begin
                n_chk++; n_bad++;
                $display("FAIL R6 strobe longer than one cycle: actual 2 cycles, expected 1");
            end
            if (left_strobe || right_strobe) begin
                n_chk++;
                if (expq.size() == 0) begin
                    n_bad++;
                    $display("FAIL %s unexpected strobe: actual strobe, expected none",
                             started ? "R6" : "R8");
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (e.ch != right_strobe) begin
                        n_bad++;
                        $display("FAIL R5 channel: actual %0d, expected %0d", right_strobe, e.ch);
                    end else if ((right_strobe ? right_sample : left_sample) != e.val) begin
                        n_bad++;
                        $display("FAIL %s ch%0d: actual %05h, expected %05h", e.tag, e.ch,
                                 right_strobe ? right_sample : left_sample, e.val);
                    end
                end
            end
            prev_l = left_strobe;
            prev_r = right_strobe;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R8: reset state
        n_chk++;
        if (left_sample !== 20'h0 || right_sample !== 20'h0 || left_strobe !== 1'b0 || right_strobe !== 1'b0) begin
            n_bad++;
            $display("FAIL R8 reset: actual %05h/%05h, expected 00000/00000", left_sample, right_sample);
        end
        // R8: a partial right word before the first frame gives no strobe
        for (int k = 0; k < 5; k++) send_bit(1'b1, 1'($urandom));
        started = 1;
        frame(3'b000, 20, 1'b0, "R1");
        run(1'b1, 2'b00, 3'b000, 20, 2, "R1");
        run(1'b1, 2'b01, 3'b000, 20, 3, "R4");   // R3 LSB-16 via pins
        run(1'b1, 2'b10, 3'b000, 20, 3, "R4");   // R3 LSB-18
        run(1'b1, 2'b11, 3'b100, 20, 3, "R4");   // reg_fmt ignored in pin mode
        run(1'b0, 2'b00, 3'b100, 20, 3, "R2");
        run(1'b0, 2'b00, 3'b111, 16, 2, "R2");
        run(1'b0, 2'b00, 3'b000, 18, 3, "R1");
        run(1'b0, 2'b01, 3'b001, 20, 3, "R3");
        run(1'b0, 2'b00, 3'b010, 20, 2, "R3");
        run(1'b0, 2'b00, 3'b011, 20, 2, "R3");
        run(1'b1, 2'b00, 3'b101, 20, 2, "R4");
        for (int k = 0; k < 3; k++) send_bit(1'b0, carry);
        repeat (20) @(negedge clk);
        n_chk++;
        if (expq.size() != 0) begin
            n_bad++;
            $display("FAIL R6 missing strobes: actual %0d left over, expected 0", expq.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule